// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one management transaction to an external PHY over a two-wire serial link: a management clock output (`mdc`) and a shared data line. The data line is split into `mdo`, `mdo_en` and `mdi`, so that the pad at the chip edge can build the bidirectional pin. A caller pulses `start` together with a read/write select, a 5-bit PHY address, a 5-bit register number and 16 bits of write data. The block then serializes a complete frame. Each frame opens with a 32-bit all-ones preamble, followed by the start pattern, the opcode, the address fields, a turnaround, the data field and one trailing clock. At the end the block returns a one-cycle `done` pulse with the 16-bit read result.

The management clock comes from the system clock. Each low phase and each high phase of `mdc` lasts `DIV` system clocks. In every bit slot the outgoing value and its enable are applied while `mdc` is low, and `mdi` is sampled during the high phase, on its last system clock.

The controller is a four-state machine:
- `ST_IDLE`: waiting for work.
- `ST_LOW`: the low half of a bit slot.
- `ST_HIGH`: the high half of a bit slot.
- `ST_DONE`: the completion cycle.

The transitions are:
- idle→low when a start is accepted.
- low→high at the end of a phase.
- high→low at the end of a phase when more slots remain; this advances the slot.
- high→done at the end of a phase on the final slot.
- done→idle unconditionally.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdo`, `mdo_en`, `busy` and `done` are all 0.
- R2: Every `mdc` low phase and every `mdc` high phase lasts exactly `DIV` system clocks, and each slot starts with its low phase.
- R3: Slots 0 to 31 drive `mdo`=1 with `mdo_en`=1.
- R4: Slot 32 drives 0 and slot 33 drives 1. The opcode in slots 34 and 35 is 1,0 for a read (`rd_sel`=1) and 0,1 for a write. All four slots have `mdo_en`=1.
- R5: Slots 36 to 40 carry the PHY address and slots 41 to 45 carry the register number, both most significant bit first, with `mdo_en`=1.
- R6: A write has 65 slots. Slots 46 and 47 are released (`mdo_en`=0). Slots 48 to 63 drive the write data MSB first with `mdo_en`=1. Slot 64 is released.
- R7: A read has 64 slots, and `mdo_en` is 0 from slot 46 to the end. Whenever `mdo_en` is 0, `mdo` is 0.
- R8: On a read, `mdi` is sampled during the high phase of slots 47 to 62. The bits are shifted in at bit 0, so slot 47 lands in bit 15. `rd_data` shows the result while `done` is high and holds it until the next completion. A write completes with `rd_data`=0.
- R9: `done` is high for exactly one cycle. Counting the edge that accepts `start` as edge 0, `done` is high after edge 2·DIV·N, where N is the slot count. `busy` is high from the edge after the accepted start through the `done` cycle, and low after it.
- R10: A `start` seen while `busy` is high, including during the `done` cycle, is ignored and does not alter the frame in flight.
- R11: After a frame, the block rests with `mdc`=0, `mdo`=0 and `mdo_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| rd_sel | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register number |
| wr_data | input | 16 | Data for a write |
| rd_data | output | 16 | Data from the last read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transaction in progress |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Outgoing data bit |
| mdo_en | output | 1 | Output enable for the data line |
| mdi | input | 1 | Incoming data bit |

## Verification
The completion pulse and a fresh request can meet in the same cycle: a caller that re-arms `start` on seeing `done` finds the block still busy. The bench raises `start` during the `done` cycle. It then checks that `busy` falls on the next cycle and that no `mdc` edge follows. A second collision is a request that arrives mid-frame with a different opcode and address. That case is judged by comparing every captured slot, and the total slot count, against the first request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } mdio_state_t;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wdata;
    } mdio_req_t;

    localparam int SLOT_W      = 7;
    localparam int PRE_LEN     = 32;
    localparam int SLOT_START  = PRE_LEN;
    localparam int SLOT_OP     = SLOT_START + 2;
    localparam int SLOT_PHY    = SLOT_OP + 2;
    localparam int SLOT_REG    = SLOT_PHY + 5;
    localparam int SLOT_TA     = SLOT_REG + 5;
    localparam int SLOT_RDATA  = SLOT_TA + 1;
    localparam int SLOT_WDATA  = SLOT_TA + 2;
    localparam int READ_LAST   = SLOT_RDATA + 16;
    localparam int WRITE_LAST  = SLOT_WDATA + 16;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_end
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign phase_end = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || phase_end)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/mdio_frame_gen.sv
module mdio_frame_gen
    import mdio_pkg::*;
(
    input  mdio_req_t         req,
    input  logic [SLOT_W-1:0] slot,
    output logic              bit_val,
    output logic              bit_oe,
    output logic              capture_slot,
    output logic              last_slot
);
    logic [SLOT_W-1:0] pa_idx;
    logic [SLOT_W-1:0] ra_idx;
    logic [SLOT_W-1:0] wd_idx;

    always_comb begin
        pa_idx  = SLOT_W'(SLOT_REG - 1) - slot;
        ra_idx  = SLOT_W'(SLOT_TA - 1) - slot;
        wd_idx  = SLOT_W'(WRITE_LAST - 1) - slot;
        bit_val = 1'b0;
        bit_oe  = 1'b0;
        if (slot < SLOT_W'(PRE_LEN)) begin
            bit_val = 1'b1;
            bit_oe  = 1'b1;
        end else if (slot == SLOT_W'(SLOT_START)) begin
            bit_oe  = 1'b1;
        end else if (slot == SLOT_W'(SLOT_START + 1)) begin
            bit_val = 1'b1;
            bit_oe  = 1'b1;
        end else if (slot == SLOT_W'(SLOT_OP)) begin
            bit_val = req.rd;
            bit_oe  = 1'b1;
        end else if (slot == SLOT_W'(SLOT_OP + 1)) begin
            bit_val = !req.rd;
            bit_oe  = 1'b1;
        end else if (slot < SLOT_W'(SLOT_REG)) begin
            bit_val = req.phy[pa_idx[2:0]];
            bit_oe  = 1'b1;
        end else if (slot < SLOT_W'(SLOT_TA)) begin
            bit_val = req.regn[ra_idx[2:0]];
            bit_oe  = 1'b1;
        end else if (!req.rd && slot >= SLOT_W'(SLOT_WDATA)
                     && slot < SLOT_W'(WRITE_LAST)) begin
            bit_val = req.wdata[wd_idx[3:0]];
            bit_oe  = 1'b1;
        end
    end

    assign capture_slot = req.rd && slot >= SLOT_W'(SLOT_RDATA)
                          && slot < SLOT_W'(READ_LAST);
    assign last_slot    = req.rd ? (slot == SLOT_W'(READ_LAST))
                                 : (slot == SLOT_W'(WRITE_LAST));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rd_sel,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        done,
    output logic        busy,
    output logic        mdc,
    output logic        mdo,
    output logic        mdo_en,
    input  logic        mdi
);
    mdio_state_t       state;
    mdio_req_t         req;
    logic [SLOT_W-1:0] slot;
    logic [15:0]       shreg;
    logic              phase_end;
    logic              bit_val;
    logic              bit_oe;
    logic              capture_slot;
    logic              last_slot;
    logic              in_slot;

    assign in_slot = (state == ST_LOW) || (state == ST_HIGH);

    mdio_phase_timer #(.DIV(DIV)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (in_slot),
        .phase_end (phase_end)
    );

    mdio_frame_gen u_frame (
        .req          (req),
        .slot         (slot),
        .bit_val      (bit_val),
        .bit_oe       (bit_oe),
        .capture_slot (capture_slot),
        .last_slot    (last_slot)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            req     <= '0;
            slot    <= '0;
            shreg   <= '0;
            rd_data <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        req   <= '{rd: rd_sel, phy: phy_addr,
                                   regn: reg_addr, wdata: wr_data};
                        slot  <= '0;
                        shreg <= '0;
                        state <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (phase_end)
                        state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        if (capture_slot)
                            shreg <= {shreg[14:0], mdi};
                        if (last_slot) begin
                            rd_data <= shreg;
                            state   <= ST_DONE;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= ST_LOW;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mdc    = (state == ST_HIGH);
        mdo    = in_slot ? (bit_val & bit_oe) : 1'b0;
        mdo_en = in_slot ? bit_oe : 1'b0;
        done   = (state == ST_DONE);
        busy   = (state != ST_IDLE);
    end

    // R2
    mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(phase_end));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(req));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo && !mdo_en));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && req.rd && slot >= SLOT_W'(SLOT_TA)) |-> !mdo_en);

    // R6
    write_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_slot && !req.rd && slot == SLOT_W'(WRITE_LAST)) |-> !mdo_en);

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int  DIV = 3;
    localparam time CLK_PERIOD = 10ns;

    typedef struct packed {
        logic        rd;
        logic [4:0]  pa;
        logic [4:0]  ra;
        logic [15:0] wd;
        logic [15:0] rsp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{rd: 1'b1, pa: 5'h01, ra: 5'h00, wd: 16'h0000, rsp: 16'hA5C3},
        '{rd: 1'b0, pa: 5'h1F, ra: 5'h04, wd: 16'h8001, rsp: 16'h0000},
        '{rd: 1'b1, pa: 5'h10, ra: 5'h1F, wd: 16'h0000, rsp: 16'hFFFF},
        '{rd: 1'b0, pa: 5'h00, ra: 5'h11, wd: 16'h3C5A, rsp: 16'h0000},
        '{rd: 1'b1, pa: 5'h15, ra: 5'h0A, wd: 16'h0000, rsp: 16'h0001},
        '{rd: 1'b0, pa: 5'h0A, ra: 5'h15, wd: 16'hFFFF, rsp: 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_sel = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        done, busy, mdc, mdo, mdo_en, mdi;

    int checks = 0;
    int errors = 0;

    int          rises = 0;
    int          base = 0;
    logic [15:0] rsp_cur = '0;
    logic [1:0]  cap [128];
    int          width_bad = 0;
    realtime     t_rise = 0;
    realtime     t_fall = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mdio_master #(.DIV(DIV)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_sel   (rd_sel),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .done     (done),
        .busy     (busy),
        .mdc      (mdc),
        .mdo      (mdo),
        .mdo_en   (mdo_en),
        .mdi      (mdi)
    );

    // PHY model: answers slot k (47..62) during its high phase
    always_comb begin
        int k;
        k = rises - base - 1;
        if (k >= 47 && k <= 62)
            mdi = rsp_cur[62 - k];
        else
            mdi = 1'b1;
    end

    always @(posedge mdc) begin
        cap[rises % 128] = {mdo_en, mdo};
        if ((rises - base) > 0 && ($realtime - t_fall) != DIV * CLK_PERIOD)
            width_bad = width_bad + 1;
        t_rise = $realtime;
        rises  = rises + 1;
    end

    always @(negedge mdc) begin
        if (($realtime - t_rise) != DIV * CLK_PERIOD)
            width_bad = width_bad + 1;
        t_fall = $realtime;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_slot(input vec_t v, input int k);
        if (k < 32)  return 2'b11;
        if (k == 32) return 2'b10;
        if (k == 33) return 2'b11;
        if (k == 34) return {1'b1, v.rd};
        if (k == 35) return {1'b1, !v.rd};
        if (k < 41)  return {1'b1, v.pa[40 - k]};
        if (k < 46)  return {1'b1, v.ra[45 - k]};
        if (!v.rd && k >= 48 && k < 64) return {1'b1, v.wd[63 - k]};
        return 2'b00;
    endfunction

    function automatic string slot_tag(input vec_t v, input int k);
        if (k < 32) return "R3 preamble";
        if (k < 36) return "R4 start/opcode";
        if (k < 46) return "R5 address";
        return v.rd ? "R7 read tail" : "R6 write tail";
    endfunction

    // inject >= 0: a conflicting start is raised that many edges into the frame
    task automatic run_txn(input vec_t v, input int inject, input bit start_in_done);
        int n, edges, wb;
        n = v.rd ? 64 : 65;
        @(negedge clk);
        base     = rises;
        rsp_cur  = v.rsp;
        wb       = width_bad;
        rd_sel   = v.rd;
        phy_addr = v.pa;
        reg_addr = v.ra;
        wr_data  = v.wd;
        start    = 1'b1;
        @(posedge clk);
        edges = 0;
        @(negedge clk);
        start    = 1'b0;
        rd_sel   = !v.rd;
        phy_addr = ~v.pa;
        reg_addr = ~v.ra;
        wr_data  = ~v.wd;
        forever begin
            if (done || edges > 5000) break;
            start = (inject >= 0 && edges == inject);
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        start = 1'b0;
        check(edges == 2 * DIV * n, "R9 done timing", edges, 2 * DIV * n);
        check(busy == 1'b1, "R9 busy during done", busy, 1);
        check(rd_data == (v.rd ? v.rsp : 16'h0000), "R8 read data", rd_data,
              v.rd ? v.rsp : 16'h0000);
        check((rises - base) == n, v.rd ? "R7 slot count" : "R6 slot count",
              rises - base, n);
        for (int k = 0; k < n && k < (rises - base); k++)
            check(cap[(base + k) % 128] == exp_slot(v, k), slot_tag(v, k),
                  cap[(base + k) % 128], exp_slot(v, k));
        if (start_in_done) start = 1'b1;   // R10: collides with the done pulse
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R9 done one cycle", done, 0);
        check(busy == 1'b0, "R9 busy released", busy, 0);
        check({mdc, mdo, mdo_en} == 3'b000, "R11 idle lines", {mdc, mdo, mdo_en}, 0);
        repeat (2 * DIV + 2) @(negedge clk);
        check(busy == 1'b0 && (rises - base) == n, "R10 start ignored at done",
              rises - base, n);
        check(width_bad == wb, "R2 mdc phase width", width_bad - wb, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check({mdc, mdo, mdo_en, busy, done} == 5'b0, "R1 reset state",
              {mdc, mdo, mdo_en, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({mdc, mdo, mdo_en, busy, done} == 5'b0, "R1 after release",
              {mdc, mdo, mdo_en, busy, done}, 0);

        for (int i = 0; i < NV; i++)
            run_txn(VECS[i], -1, 1'b0);

        // R10: request mid-frame with opposite opcode and address
        run_txn(VECS[1], 100, 1'b0);
        run_txn(VECS[0], 250, 1'b1);
        // R8: hold value checked after a following write
        run_txn(VECS[3], -1, 1'b1);
        check(rd_data == 16'h0000, "R8 write clears read data", rd_data, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule